// File: doc/BRIEF.md
# Glitch-Free Card Clock Selector

This block produces the clock for a smart-card contact from one of two sources. The first is a host-driven clock pin that passes straight through to the card. The second is a free-running system clock that reaches the card either undivided, halved or quartered. The host picks the source and the ratio by pulling the chip-select low with the programming strobe also low, presenting the setting, and raising chip-select; the setting is captured on that rising edge.

Changes of source or ratio never cut an output cycle short. The divided path only switches at the end of a complete output cycle. The two sources hand over break-before-make, so they never drive the output together. The host-clock path is tied to chip-select: it is live while chip-select is low and holds its last level while chip-select is high. This keeps card data and clock consistent. The system-clock path ignores chip-select and keeps the card running when the block is deselected.

Top module: `card_clk_sel`

## Requirements
- R1: `prog_div` code 00 passes the system clock undivided, 01 divides it by 2 and 10 or 11 divides it by 4; the divided outputs have equal high and low phases of 1 and 2 system-clock periods.
- R2: A setting is captured only on a rising edge of `cs_n` while `prog_n` is low; a rising edge with `prog_n` high leaves source and ratio unchanged.
- R3: With the host source selected (`prog_sync` = 1 when captured) and `cs_n` low, `card_clk` follows `sync_clk` combinationally.
- R4: With the host source selected and `cs_n` high, `card_clk` holds the level `sync_clk` had when `cs_n` rose.
- R5: With the system-clock source selected, `card_clk` keeps toggling at the programmed ratio while `cs_n` is high.
- R6: During a ratio change no `card_clk` high or low phase is shorter than the shorter, or longer than the longer, half-period of the old and new ratios.
- R7: A change of source is break-before-make: the host path is never enabled while the divided path is in an output cycle, and once the host source is in effect no divided pulses appear.
- R8: While `rst_n` is low `card_clk` is low; after release the system-clock source at ratio 1 is in effect, and its first output pulse has a full high phase.
- R9: A new ratio is in effect for every output cycle that starts 9 or more system-clock rising edges after the capturing `cs_n` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| asy_clk | input | 1 | Free-running system clock, source of the divided path |
| sync_clk | input | 1 | Host-driven clock passed to the card when selected |
| cs_n | input | 1 | Active-low chip-select; its rising edge captures a setting |
| prog_n | input | 1 | Active-low programming strobe, qualifies the capture |
| prog_sync | input | 1 | Source to capture: 1 host clock, 0 system clock |
| prog_div | input | 2 | Ratio to capture: 00 /1, 01 /2, 10 or 11 /4 |
| card_clk | output | 1 | Clock driven to the card |

## Verification
The host-clock path has no register between `sync_clk` and `card_clk`, so those checks sample 1 to 2 ns after the bench moves `sync_clk` or `cs_n`. A captured setting crosses two synchronizer flops and one stability compare into the system-clock domain. It then waits for the current output cycle to end, which is at most four system-clock edges later. The bench therefore waits nine rising edges after each capture before timing a full high and low phase of the new ratio. A monitor times every `card_clk` phase across each ratio change against the bounds of R6, and source handovers are given twenty edges to settle before their results are sampled.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;
  localparam int MAX_RATIO = 4;
  localparam int CNT_W     = $clog2(MAX_RATIO);

  typedef enum logic [1:0] {
    DIV1 = 2'd0,
    DIV2 = 2'd1,
    DIV4 = 2'd2
  } div_e;

  typedef struct packed {
    logic use_sync;
    div_e div;
  } clk_cfg_t;

  localparam int       CFG_W     = $bits(clk_cfg_t);
  localparam clk_cfg_t CFG_RESET = '{use_sync: 1'b0, div: DIV1};

  function automatic div_e decode_div(input logic [1:0] code);
    case (code)
      2'b00:   return DIV1;
      2'b01:   return DIV2;
      default: return DIV4;
    endcase
  endfunction

  // index of the last input cycle inside one output cycle
  function automatic logic [CNT_W-1:0] last_cnt(input div_e d);
    case (d)
      DIV1:    return CNT_W'(0);
      DIV2:    return CNT_W'(1);
      default: return CNT_W'(MAX_RATIO - 1);
    endcase
  endfunction

  // number of input cycles the divided output stays high
  function automatic logic [CNT_W-1:0] high_cnt(input div_e d);
    case (d)
      DIV2:    return CNT_W'(1);
      DIV4:    return CNT_W'(MAX_RATIO / 2);
      default: return CNT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/ccs_sync_bits.sv
`timescale 1ns/1ps
module ccs_sync_bits #(
  parameter int                WIDTH   = 1,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ccs_cfg_latch.sv
`timescale 1ns/1ps
module ccs_cfg_latch
  import ccs_pkg::*;
(
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       prog_n,
  input  logic       prog_sync,
  input  logic [1:0] prog_div,
  output clk_cfg_t   cfg
);
  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (!prog_n) begin
      cfg.use_sync <= prog_sync;
      cfg.div      <= decode_div(prog_div);
    end
  end
endmodule

// File: rtl/ccs_sync_gate.sv
`timescale 1ns/1ps
module ccs_sync_gate (
  input  logic rst_n,
  input  logic cs_n,
  input  logic sync_clk,
  output logic live
);
  logic hold;

  // level seen on the host clock when the chip is deselected
  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n) hold <= 1'b0;
    else        hold <= sync_clk;
  end

  assign live = cs_n ? hold : sync_clk;
endmodule

// File: rtl/ccs_async_seq.sv
`timescale 1ns/1ps
module ccs_async_seq
  import ccs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     asy_clk,
  input  logic     rst_n,
  input  clk_cfg_t cfg_in,
  input  logic     sync_live,
  output logic     sync_en,
  output logic     busy,
  output logic     gate1,
  output logic     div_q,
  output div_e     cur_div
);
  logic [CFG_W-1:0] cfg_sync_bits;
  logic             live_s;
  clk_cfg_t         cfg_s, cfg_seen, want;
  logic [CNT_W-1:0] cnt;
  logic             boundary, start;

  ccs_sync_bits #(.WIDTH(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL(CFG_RESET)) u_cfg_sync (
    .clk(asy_clk), .rst_n(rst_n), .d(cfg_in), .q(cfg_sync_bits)
  );

  ccs_sync_bits #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_live_sync (
    .clk(asy_clk), .rst_n(rst_n), .d(sync_live), .q(live_s)
  );

  assign cfg_s = clk_cfg_t'(cfg_sync_bits);

  // accept a setting only once two samples agree, so bits never mix
  always_ff @(posedge asy_clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_seen <= CFG_RESET;
      want     <= CFG_RESET;
    end else begin
      cfg_seen <= cfg_s;
      if (cfg_s == cfg_seen) want <= cfg_s;
    end
  end

  assign boundary = !busy || (cnt == last_cnt(cur_div));
  assign start    = !want.use_sync && !sync_en;

  always_ff @(posedge asy_clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cur_div <= DIV1;
      cnt     <= '0;
      div_q   <= 1'b0;
      sync_en <= 1'b0;
    end else begin
      if (boundary) begin
        busy    <= start;
        cur_div <= want.div;
        cnt     <= '0;
        div_q   <= start && (want.div != DIV1);
      end else begin
        cnt   <= CNT_W'(cnt + 1'b1);
        div_q <= CNT_W'(cnt + 1'b1) < high_cnt(cur_div);
      end
      sync_en <= want.use_sync && (sync_en || (!busy && !live_s));
    end
  end

  // undivided output: enable moves only while the system clock is low
  always_ff @(negedge asy_clk or negedge rst_n) begin
    if (!rst_n) gate1 <= 1'b0;
    else        gate1 <= boundary && start && (want.div == DIV1);
  end
endmodule

// File: rtl/card_clk_sel.sv
`timescale 1ns/1ps
module card_clk_sel
  import ccs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       rst_n,
  input  logic       asy_clk,
  input  logic       sync_clk,
  input  logic       cs_n,
  input  logic       prog_n,
  input  logic       prog_sync,
  input  logic [1:0] prog_div,
  output logic       card_clk
);
  clk_cfg_t cfg_q;
  logic     sync_live, sync_en, a_busy, gate1, div_q;
  div_e     cur_div;

  ccs_cfg_latch u_cfg (
    .rst_n(rst_n), .cs_n(cs_n), .prog_n(prog_n),
    .prog_sync(prog_sync), .prog_div(prog_div), .cfg(cfg_q)
  );

  ccs_sync_gate u_sgate (
    .rst_n(rst_n), .cs_n(cs_n), .sync_clk(sync_clk), .live(sync_live)
  );

  ccs_async_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .asy_clk(asy_clk), .rst_n(rst_n), .cfg_in(cfg_q), .sync_live(sync_live),
    .sync_en(sync_en), .busy(a_busy), .gate1(gate1), .div_q(div_q),
    .cur_div(cur_div)
  );

  assign card_clk = (asy_clk & gate1) | div_q | (sync_en & sync_live);
endmodule

// File: rtl/ccs_chk.sv
`timescale 1ns/1ps
module ccs_chk
  import ccs_pkg::*;
(
  input logic     rst_n,
  input logic     asy_clk,
  input logic     cs_n,
  input logic     prog_n,
  input logic     card_clk,
  input clk_cfg_t cfg_q,
  input logic     sync_en,
  input logic     a_busy,
  input logic     gate1,
  input logic     div_q,
  input div_e     cur_div
);
  AST_NO_OVERLAP: assert property (@(posedge asy_clk) disable iff (!rst_n)
    !(sync_en && (a_busy || gate1))) else $error("sources overlap"); // R7

  AST_HALF_TOGGLE: assert property (@(posedge asy_clk) disable iff (!rst_n)
    (a_busy && $past(a_busy) && cur_div == DIV2 && $past(cur_div) == DIV2)
      |-> (div_q != $past(div_q))) else $error("divide-by-2 duty"); // R1

  AST_CFG_IGNORED: assert property (@(posedge cs_n) disable iff (!rst_n)
    prog_n |=> $stable(cfg_q)) else $error("capture without strobe"); // R2

  AST_SYNC_FROZEN: assert property (@(posedge asy_clk) disable iff (!rst_n)
    (sync_en && $past(sync_en) && cs_n && $past(cs_n)) |-> $stable(card_clk))
    else $error("host clock not frozen"); // R4

  always @(gate1) begin
    if (rst_n) begin
      AST_GATE_QUIET: assert (!asy_clk) else $error("gate moved while high"); // R6
    end
  end

  always @(negedge asy_clk) begin
    if (!rst_n) begin
      AST_RESET_LOW: assert (!card_clk) else $error("output high in reset"); // R8
    end
  end
endmodule

bind card_clk_sel ccs_chk u_chk (
  .rst_n(rst_n), .asy_clk(asy_clk), .cs_n(cs_n), .prog_n(prog_n),
  .card_clk(card_clk), .cfg_q(cfg_q), .sync_en(sync_en), .a_busy(a_busy),
  .gate1(gate1), .div_q(div_q), .cur_div(cur_div)
);

// File: tb/sim_card_clk_sel.sv
`timescale 1ns/1ps
module sim_card_clk_sel;
  logic       rst_n = 1'b0;
  logic       asy_clk = 1'b0;
  logic       sync_clk = 1'b0;
  logic       cs_n = 1'b1;
  logic       prog_n = 1'b1;
  logic       prog_sync = 1'b0;
  logic [1:0] prog_div = 2'b00;
  logic       card_clk;

  int checks = 0;
  int errors = 0;

  always #4 asy_clk = ~asy_clk;   // 125 MHz

  card_clk_sel u0 (
    .rst_n(rst_n), .asy_clk(asy_clk), .sync_clk(sync_clk), .cs_n(cs_n),
    .prog_n(prog_n), .prog_sync(prog_sync), .prog_div(prog_div),
    .card_clk(card_clk)
  );

  // ratio code, expected half-period in ns
  localparam logic [7:0] VEC [7] = '{
    {2'b01, 6'd8}, {2'b10, 6'd16}, {2'b00, 6'd4}, {2'b11, 6'd16},
    {2'b01, 6'd8}, {2'b00, 6'd4},  {2'b10, 6'd16}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // phase monitor for ratio changes
  bit      mon_en = 1'b0;
  bit      armed  = 1'b0;
  realtime t_last = 0.0;
  int      lo_b = 0, hi_b = 0, viol = 0, mon_d = 0;
  int      pcount = 0;

  always @(card_clk) begin
    if (mon_en) begin
      if (armed) begin
        mon_d = int'($realtime - t_last);
        if (mon_d < lo_b || mon_d > hi_b) viol++;
      end
      armed = 1'b1;
    end else begin
      armed = 1'b0;
    end
    t_last = $realtime;
  end

  always @(posedge card_clk) pcount++;

  task automatic measure(output int hi, output int lo);
    realtime t0, t1, t2;
    @(posedge card_clk); t0 = $realtime;
    @(negedge card_clk); t1 = $realtime;
    @(posedge card_clk); t2 = $realtime;
    hi = int'(t1 - t0);
    lo = int'(t2 - t1);
  endtask

  task automatic program_cfg(input bit src, input logic [1:0] code);
    @(negedge asy_clk);
    cs_n = 1'b0; prog_n = 1'b0; prog_sync = src; prog_div = code;
    #22 cs_n = 1'b1;
    #5  prog_n = 1'b1;
  endtask

  int h, l, cur, expv, pstart;

  initial begin
    repeat (3) @(posedge asy_clk);
    #1 chk(card_clk == 1'b0, "R8 output low in reset", int'(card_clk), 0);
    @(posedge asy_clk); #1 rst_n = 1'b1;
    measure(h, l);
    chk(h == 4, "R8 first pulse full high phase", h, 4);
    chk(l == 4, "R8 default ratio 1 low phase", l, 4);

    // table of ratio changes on the system-clock source
    cur = 4;
    mon_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      expv = int'(VEC[i][5:0]);
      lo_b = (cur < expv) ? cur : expv;
      hi_b = (cur > expv) ? cur : expv;
      program_cfg(1'b0, VEC[i][7:6]);
      repeat (9) @(posedge asy_clk);
      measure(h, l);
      chk(h == expv, "R1 high phase of programmed ratio", h, expv);
      chk(l == expv, "R9 low phase after latency window", l, expv);
      chk(viol == 0, "R6 phases within old/new bounds", viol, 0);
      cur = expv;
    end
    mon_en = 1'b0;

    // hand over to the host clock
    sync_clk = 1'b0;
    program_cfg(1'b1, 2'b00);
    @(negedge asy_clk); cs_n = 1'b0;
    repeat (20) @(posedge asy_clk);
    pstart = pcount;
    repeat (20) @(posedge asy_clk);
    chk(pcount == pstart, "R7 no divided pulses after handover", pcount - pstart, 0);

    #3 sync_clk = 1'b1; #1 chk(card_clk == 1'b1, "R3 follows host clock high", int'(card_clk), 1);
    #3 sync_clk = 1'b0; #1 chk(card_clk == 1'b0, "R3 follows host clock low", int'(card_clk), 0);
    #5 sync_clk = 1'b1; #2 chk(card_clk == 1'b1, "R3 follows host clock again", int'(card_clk), 1);

    // deselect with host clock high, strobe inactive, new values presented
    prog_sync = 1'b0; prog_div = 2'b01;
    #2 cs_n = 1'b1;
    #3 sync_clk = 1'b0;
    #2 chk(card_clk == 1'b1, "R4 frozen at level seen on deselect", int'(card_clk), 1);
    repeat (20) @(posedge asy_clk);
    #1 chk(card_clk == 1'b1, "R2 setting kept when strobe high", int'(card_clk), 1);

    // back to system clock /2 with the host level frozen high
    @(negedge asy_clk);
    sync_clk = 1'b1; cs_n = 1'b0; prog_n = 1'b0; prog_sync = 1'b0; prog_div = 2'b01;
    #22 cs_n = 1'b1;
    #5  prog_n = 1'b1; sync_clk = 1'b0;
    repeat (12) @(posedge asy_clk);
    measure(h, l);
    chk(h == 8, "R5 runs while deselected, high", h, 8);
    chk(l == 8, "R5 runs while deselected, low", l, 8);
    @(negedge asy_clk);
    pstart = pcount;
    repeat (16) @(negedge asy_clk);
    chk(pcount - pstart == 8, "R5 pulse count while deselected", pcount - pstart, 8);

    // reset during operation
    @(posedge asy_clk); #6 rst_n = 1'b0;
    #1 chk(card_clk == 1'b0, "R8 output low on reset", int'(card_clk), 0);
    repeat (2) @(posedge asy_clk);
    @(posedge asy_clk); #1 rst_n = 1'b1;
    measure(h, l);
    chk(h == 4, "R8 ratio 1 after reset, high", h, 4);
    chk(l == 4, "R8 ratio 1 after reset, low", l, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog R1 to R9 run did not finish actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule